// File: doc/BRIEF.md
# Programmable Root Timer Channel

This block is a single general-purpose timer channel. It holds a count, a mode word and a target, each reachable through a small register port with a two-bit address. The count advances on one of four selectable clock enables. It is compared against the target and against its own wrap. Matches can raise a one-cycle interrupt pulse and set sticky status flags in the mode word.

Software sets the channel up by writing the target and then the mode word. Writing the mode word clears the count and re-arms a one-shot interrupt. The channel can either restart from zero when it reaches the target, or run on through the target to all ones and wrap. Status flags collect events until software reads the mode word, and that read clears the flags for the target and for the wrap. A stop gate held in the mode word freezes the count.

Top module: `rtmr_channel`

## Requirements
- R1: Address 0 selects the count, address 1 the mode word, and address 2 the target; address 3 reads as zero. A write to the count loads the 16-bit data. A write to the target is read back unchanged. `rdata` shows the addressed register combinationally.
- R2: Mode bits 9:8 pick the advance enable: 00 advances every clock, 01 on each cycle with `dot_tick` high, 10 once every 8 clocks (from a free-running 3-bit prescaler that starts at reset), and 11 on each cycle with `line_tick` high.
- R3: When mode bit 0 is 1 and mode bits 2:1 are 00 or 11, the count holds. For the other two values of bits 2:1 the count advances normally.
- R4: With mode bit 3 set, an advance whose incremented value equals the target loads 0 instead.
- R5: With mode bit 3 clear, the count passes through the target, goes on to 0xFFFF, and then wraps to 0.
- R6: A target match sets mode bit 11 and a wrap sets mode bit 12; either event sets mode bit 10. A mode read (`rd_en` with address 1) clears bits 11 and 12 at that clock edge but leaves bit 10 set. An event in the same cycle as the read still sets its flag.
- R7: A mode write loads bits 9:0, zeroes the count, clears bits 10 to 12, and re-arms a one-shot interrupt.
- R8: Mode bit 4 enables the interrupt on a target match and bit 5 enables it on a wrap. `irq_pulse` is high for one cycle, registered at the same edge that updates the count. A target match and a wrap in the same advance give one pulse.
- R9: With mode bit 6 clear, only the first enabled event after a mode write pulses. With bit 6 set, every enabled event pulses.
- R10: Mode bits 15:13 always read zero. Bits 12:10 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of the mode word has a side effect) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| dot_tick | input | 1 | External dot-rate enable |
| line_tick | input | 1 | External line-rate enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches several rules on every cycle: a mode write clears the count on the next edge, the stop gate freezes the count, a spent one-shot produces no further pulse, any pulse comes with the event flag set, and the top three mode bits stay zero. The bench's scenarios are needed for the rest. They show the advance rate of each source, the restart-at-target and wrap sequences, the clear-on-read of the status flags, and the merging of a target match and a wrap that land in the same advance. A cycle-by-cycle model checks all of these.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
   localparam int unsigned DATA_W      = 16;
   localparam int unsigned MB_SYNC_EN  = 0;
   localparam int unsigned MB_SYNC_LO  = 1;
   localparam int unsigned MB_RST_TGT  = 3;
   localparam int unsigned MB_IRQ_TGT  = 4;
   localparam int unsigned MB_IRQ_OVF  = 5;
   localparam int unsigned MB_IRQ_RPT  = 6;
   localparam int unsigned MB_SRC_LO   = 8;
   localparam int unsigned MB_ANY_EVT  = 10;
   localparam int unsigned MB_HIT_TGT  = 11;
   localparam int unsigned MB_HIT_OVF  = 12;
   localparam int unsigned MB_WR_TOP   = 9;

   typedef enum logic [1:0] {
      SRC_SYS  = 2'b00,
      SRC_DOT  = 2'b01,
      SRC_DIV  = 2'b10,
      SRC_LINE = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_MODE   = 2'd1,
      REG_TARGET = 2'd2,
      REG_NONE   = 2'd3
   } reg_e;
endpackage

// File: rtl/rtmr_tick_sel.sv
module rtmr_tick_sel
   import rtmr_pkg::*;
#(
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  src_e src,
   input  logic dot_tick,
   input  logic line_tick,
   output logic tick
);
   logic div_tick;

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         assign div_tick = 1'b1;
      end else begin : g_div
         logic [DIV_LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
         end
         assign div_tick = &pre_q;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_SYS:  tick = 1'b1;
         SRC_DOT:  tick = dot_tick;
         SRC_DIV:  tick = div_tick;
         SRC_LINE: tick = line_tick;
         default:  tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear,
   input  logic [CNT_W-1:0] target,
   input  logic             rst_at_tgt,
   output logic [CNT_W-1:0] cnt,
   output logic             tgt_evt,
   output logic             ovf_evt
);
   logic [CNT_W:0]   inc;
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step    = adv & ~load & ~clear;
   assign inc     = {1'b0, cnt_q} + 1'b1;
   assign tgt_evt = step & (inc[CNT_W-1:0] == target);
   assign ovf_evt = step & inc[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clear)                  cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (tgt_evt && rst_at_tgt)  cnt_q <= '0;
      else if (step)                   cnt_q <= inc[CNT_W-1:0];
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
   import rtmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tgt_evt,
   input  logic              ovf_evt,
   output logic [DATA_W-1:0] mode,
   output logic              run,
   output logic              fired,
   output logic              irq_pulse
);
   logic [DATA_W-1:0] mode_q, mode_n;
   logic              fired_q, irq_q, fire;
   logic [1:0]        sync_sel;

   assign sync_sel = mode_q[MB_SYNC_LO +: 2];
   assign run = ~(mode_q[MB_SYNC_EN] & ((sync_sel == 2'b00) | (sync_sel == 2'b11)));

   assign fire = ((tgt_evt & mode_q[MB_IRQ_TGT]) | (ovf_evt & mode_q[MB_IRQ_OVF]))
                 & (mode_q[MB_IRQ_RPT] | ~fired_q);

   always_comb begin
      mode_n = mode_q;
      if (mode_rd) begin
         mode_n[MB_HIT_TGT] = 1'b0;
         mode_n[MB_HIT_OVF] = 1'b0;
      end
      if (tgt_evt) begin
         mode_n[MB_HIT_TGT] = 1'b1;
         mode_n[MB_ANY_EVT] = 1'b1;
      end
      if (ovf_evt) begin
         mode_n[MB_HIT_OVF] = 1'b1;
         mode_n[MB_ANY_EVT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         fired_q <= 1'b0;
         irq_q   <= 1'b0;
      end else if (mode_wr) begin
         mode_q  <= {{(DATA_W-MB_WR_TOP-1){1'b0}}, wdata[MB_WR_TOP:0]};
         fired_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         mode_q  <= mode_n;
         irq_q   <= fire;
         if (fire) fired_q <= 1'b1;
      end
   end

   assign mode      = mode_q;
   assign fired     = fired_q;
   assign irq_pulse = irq_q;
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
   import rtmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              dot_tick,
   input  logic              line_tick,
   output logic              irq_pulse
);
   generate
      if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_width
         $error("rtmr_channel: CNT_W must lie in 4..16");
      end
      if (DIV_LOG2 > 8) begin : g_bad_div
         $error("rtmr_channel: DIV_LOG2 must be at most 8");
      end
   endgenerate

   localparam int unsigned PAD_W = DATA_W - CNT_W;

   reg_e              sel;
   logic              cnt_wr, mode_wr, tgt_wr, mode_rd;
   logic [DATA_W-1:0] mode_w;
   logic [CNT_W-1:0]  cnt_w, tgt_q;
   logic              tick_w, run_w, fired_w, tgt_evt_w, ovf_evt_w;

   assign sel     = reg_e'(addr);
   assign cnt_wr  = wr_en & (sel == REG_COUNT);
   assign mode_wr = wr_en & (sel == REG_MODE);
   assign tgt_wr  = wr_en & (sel == REG_TARGET);
   assign mode_rd = rd_en & ~wr_en & (sel == REG_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_q <= '0;
      else if (tgt_wr) tgt_q <= wdata[CNT_W-1:0];
   end

   rtmr_tick_sel #(.DIV_LOG2(DIV_LOG2)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_e'(mode_w[MB_SRC_LO +: 2])),
      .dot_tick  (dot_tick),
      .line_tick (line_tick),
      .tick      (tick_w)
   );

   rtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (tick_w & run_w),
      .load       (cnt_wr),
      .load_val   (wdata[CNT_W-1:0]),
      .clear      (mode_wr),
      .target     (tgt_q),
      .rst_at_tgt (mode_w[MB_RST_TGT]),
      .cnt        (cnt_w),
      .tgt_evt    (tgt_evt_w),
      .ovf_evt    (ovf_evt_w)
   );

   rtmr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_rd   (mode_rd),
      .wdata     (wdata),
      .tgt_evt   (tgt_evt_w),
      .ovf_evt   (ovf_evt_w),
      .mode      (mode_w),
      .run       (run_w),
      .fired     (fired_w),
      .irq_pulse (irq_pulse)
   );

   generate
      if (PAD_W == 0) begin : g_full
         always_comb begin
            unique case (sel)
               REG_COUNT:  rdata = cnt_w;
               REG_MODE:   rdata = mode_w;
               REG_TARGET: rdata = tgt_q;
               default:    rdata = '0;
            endcase
         end
      end else begin : g_pad
         always_comb begin
            unique case (sel)
               REG_COUNT:  rdata = {{PAD_W{1'b0}}, cnt_w};
               REG_MODE:   rdata = mode_w;
               REG_TARGET: rdata = {{PAD_W{1'b0}}, tgt_q};
               default:    rdata = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/rtmr_channel_chk.sv
module rtmr_channel_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [15:0]      rdata,
   input logic             irq_pulse,
   input logic [CNT_W-1:0] cnt_q,
   input logic [15:0]      mode_q,
   input logic             fired_q
);
   logic mode_wr, stopped;
   assign mode_wr = wr_en && (addr == 2'd1);
   assign stopped = mode_q[0] && ((mode_q[2:1] == 2'b00) || (mode_q[2:1] == 2'b11));

   AST_MODE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (cnt_q == '0));                                    // R7
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !wr_en) |=> $stable(cnt_q));                       // R3
   AST_ONESHOT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !mode_q[6] && !mode_wr) |=> !irq_pulse);           // R9
   AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> mode_q[10]);                                     // R8
   AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd1) |-> (rdata[15:13] == 3'b000));                  // R10
endmodule

bind rtmr_channel rtmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .rdata     (rdata),
   .irq_pulse (irq_pulse),
   .cnt_q     (cnt_w),
   .mode_q    (mode_w),
   .fired_q   (fired_w)
);

// File: tb/rtmr_channel_test.sv
module rtmr_channel_test;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        dot_tick = 1'b0, line_tick = 1'b0;
   logic        irq_pulse;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   int m_cnt, m_mode, m_tgt, m_fired, m_pre, m_irq;

   always #(PERIOD/2) clk = ~clk;

   rtmr_channel uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .dot_tick(dot_tick), .line_tick(line_tick),
      .irq_pulse(irq_pulse)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      int src, sm, nxt;
      bit adv, tev, ovf, stop;
      if (!rst_n) begin
         m_cnt = 0; m_mode = 0; m_tgt = 0; m_fired = 0; m_pre = 0; m_irq = 0;
      end else begin
         src  = (m_mode >> 8) & 3;
         sm   = (m_mode >> 1) & 3;
         stop = (m_mode & 1) && (sm == 0 || sm == 3);
         case (src)
            0: adv = 1;
            1: adv = dot_tick;
            2: adv = (m_pre == 7);
            default: adv = line_tick;
         endcase
         adv = adv && !stop;
         m_pre = (m_pre + 1) & 7;
         m_irq = 0;
         if (wr_en && addr == 2'd1) begin
            m_mode = wdata & 16'h03FF; m_cnt = 0; m_fired = 0;
         end else begin
            if (rd_en && addr == 2'd1) m_mode = m_mode & 16'hE7FF;
            if (wr_en && addr == 2'd0) m_cnt = wdata;
            else if (adv) begin
               nxt = m_cnt + 1;
               ovf = (nxt == 65536);
               nxt = nxt & 16'hFFFF;
               tev = (nxt == m_tgt);
               if (tev && m_mode[3]) nxt = 0;
               m_cnt = nxt;
               if (tev) m_mode = m_mode | 16'h0C00;
               if (ovf) m_mode = m_mode | 16'h1400;
               if (((tev && m_mode[4]) || (ovf && m_mode[5])) && (m_mode[6] || !m_fired)) begin
                  m_irq = 1; m_fired = 1;
               end
            end
            if (wr_en && addr == 2'd2) m_tgt = wdata;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int exp_rdata();
      case (addr)
         2'd0: return m_cnt;
         2'd1: return m_mode;
         2'd2: return m_tgt;
         default: return 0;
      endcase
   endfunction

   task automatic cyc(input bit w, input bit r, input int a, input int d, input bit dt, input bit lt);
      wr_en = w; rd_en = r; addr = a[1:0]; wdata = d[15:0]; dot_tick = dt; line_tick = lt;
      @(negedge clk);
      check(cur_req, rdata, exp_rdata(), "rdata");
      check(cur_req, irq_pulse, m_irq, "irq_pulse");
   endtask

   task automatic wr(input int a, input int d);
      cyc(1, 0, a, d, 0, 0);
   endtask

   task automatic run(input int n, input int a);
      for (int i = 0; i < n; i++) cyc(0, 0, a, 0, (i % 3) == 0, (i % 5) == 1);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1", rdata, 0, "reset count");
      addr = 2'd1; #1;
      check("R1", rdata, 0, "reset mode");
      rst_n = 1'b1;
      @(negedge clk);
      // R1: register access, count counts on system clock
      wr(2, 16'h0010); run(2, 2); run(2, 3);
      wr(0, 16'h1234); run(4, 0);
      // R2: clock sources
      cur_req = "R2";
      wr(1, 16'h0100); run(12, 0);
      wr(1, 16'h0200); run(30, 0);
      wr(1, 16'h0300); run(15, 0);
      // R3: stop gate and non-stopping sync modes
      cur_req = "R3";
      wr(1, 16'h0001); run(8, 0);
      wr(1, 16'h0003); run(8, 0);
      wr(1, 16'h0005); run(8, 0);
      wr(1, 16'h0007); run(8, 0);
      // R4 + R9 one-shot: reset at target with target irq
      cur_req = "R4";
      wr(2, 5); wr(1, 16'h0018); run(20, 0);
      cur_req = "R9";
      run(12, 0);
      wr(1, 16'h0058); run(20, 0);
      // R7: mode write re-arms the one-shot
      cur_req = "R7";
      wr(1, 16'h0018); run(3, 1); run(8, 0);
      // R5 + R6: free run through target to wrap, flags and clear-on-read
      cur_req = "R5";
      wr(2, 16'h0008); wr(1, 16'h0030); run(12, 0);
      wr(0, 16'hFFF0); run(24, 0);
      cur_req = "R6";
      run(2, 1);
      cyc(0, 1, 1, 0, 0, 0); run(3, 1);
      cyc(0, 1, 1, 0, 0, 0); run(2, 1);
      // R8: coincident target and wrap give one pulse
      cur_req = "R8";
      wr(2, 0); wr(1, 16'h0078); wr(0, 16'hFFFC); run(8, 0); run(2, 1);
      wr(1, 16'h0020); wr(0, 16'hFFFE); run(6, 0);
      // R10: top bits and status bits not writable
      cur_req = "R10";
      wr(1, 16'hFFFF); run(4, 1);
      wr(1, 16'h1C00); run(3, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule